// File: doc/BRIEF.md
# Eight-Bit ALU with Registered Status Flags

This block is the arithmetic and logic unit of a small four-register, accumulator-style processor. It takes two operands and a four-bit operation code, which the instruction decoder derives from the opcode. The result is computed combinationally in the same cycle, together with a write-back qualifier that tells the register file whether the destination should be written.

Three status flags are kept in a register inside the block: zero, sign and overflow. On a clock edge they load the flag values that the current operation produces, but only when the flag-update enable is high and the operation is one that is allowed to touch them. The decoder holds the enable low for moves, branches, stack and I/O instructions, so those leave the flags as they were.

The compare operation produces flags but no write-back. A pass-through code lets operand B travel through the block without ever disturbing the flags. The reset is asynchronous and active-low. Its release is synchronized inside the block before it reaches the flag register.

Top module: `alu8_flags`

## Requirements
- R1: Codes 0 (add), 1 (subtract A-B), 4 (increment A) and 5 (decrement A) give their result modulo 2^W on `result`, and `result_we` is 1.
- R2: Code 2 (multiply) gives the low W bits of the unsigned product. Its overflow flag value is 1 exactly when the full product exceeds 2^W-1.
- R3: Code 3 (divide) gives the unsigned quotient A/B with overflow value 0. When B is 0, the result is all ones and the overflow value is 1.
- R4: Codes 6 (AND), 7 (OR), 8 (XOR) and 9 (NOT of A) act bitwise and give an overflow value of 0.
- R5: Code 10 rotates A left, with the old bit W-1 entering bit 0. Code 11 rotates A right, with the old bit 0 entering bit W-1. Both give an overflow value of 0.
- R6: Code 12 shifts A left and code 13 shifts A right. Each discards the bit shifted out, fills the vacated bit with 0, and gives an overflow value of 0.
- R7: For every code except 14, the zero flag value is 1 when `result` is 0, and the sign flag value equals bit W-1 of `result`.
- R8: For codes 0, 1, 4 and 5, the overflow flag value is the two's-complement signed overflow of the W-bit operation.
- R9: Code 14 (compare) gives zero = (A == B), sign = (A < B, unsigned) and overflow = 0. `result` equals A and `result_we` is 0.
- R10: The flag outputs are registered. They are 0 during reset and for the two clock edges after its release. On a later edge they load the operation's flag values when `flag_en` is 1, and otherwise they hold.
- R11: Code 15 (pass) puts B on `result` with `result_we` = 1, and the flags hold even when `flag_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | W | First operand (destination value) |
| op_b | input | W | Second operand (source or immediate) |
| op_sel | input | 4 | Operation code (see R1 to R11) |
| flag_en | input | 1 | Flag-update enable for this cycle |
| result | output | W | Combinational result |
| result_we | output | 1 | Destination should be written |
| flag_z | output | 1 | Registered zero flag |
| flag_s | output | 1 | Registered sign flag |
| flag_o | output | 1 | Registered overflow flag |

## Verification
In any one cycle, the combinational result of a new operation coincides with the flag register, which either holds the flags of an earlier operation or captures the new ones. The bench sweeps every operation code over every value of A and a spread of B values, including 0, 1, 0x80, all ones and B equal to A. It drops `flag_en` on a fixed fraction of those cycles. Each result is compared at once with an arithmetic model, and after each edge the flags are compared with a model that loads only on enabled cycles that are not pass cycles. A held flag that has been overwritten, or a captured flag that is stale, therefore shows up as a mismatch.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_DIV  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_NOT  = 4'd9,
    OP_ROL  = 4'd10,
    OP_ROR  = 4'd11,
    OP_SHL  = 4'd12,
    OP_SHR  = 4'd13,
    OP_CMP  = 4'd14,
    OP_PASS = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic s;
    logic o;
  } alu_flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);

  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end

endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod_lo,
  output logic         ovf
);

  localparam int PW = 2 * W;

  logic [PW-1:0] prod;

  always_comb begin
    prod    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    prod_lo = prod[W-1:0];
    ovf     = |prod[PW-1:W];
  end

endmodule

// File: rtl/alu8_div.sv
module alu8_div #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         by_zero
);

  logic [W-1:0] rem_s [0:W];
  logic [W-1:0] q_raw;

  assign rem_s[0] = '0;

  for (genvar k = 0; k < W; k++) begin : g_stage
    localparam int BIT = W - 1 - k;
    logic [W:0] trial;
    logic [W:0] diff;
    assign trial        = {rem_s[k], a[BIT]};
    assign diff         = trial - {1'b0, b};
    assign q_raw[BIT]   = ~diff[W];
    assign rem_s[k+1]   = diff[W] ? trial[W-1:0] : diff[W-1:0];
  end

  always_comb begin
    by_zero = (b == '0);
    quot    = by_zero ? '1 : q_raw;
    rem     = rem_s[W];
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      OP_ROL:  res = {a[W-2:0], a[W-1]};
      OP_ROR:  res = {a[0], a[W-1:1]};
      OP_SHL:  res = {a[W-2:0], 1'b0};
      OP_SHR:  res = {1'b0, a[W-1:1]};
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_int_n,
  input  logic       load,
  input  alu_flags_t nxt,
  output alu_flags_t flags
);

  alu_flags_t flags_d;
  alu_flags_t flags_q;

  always_comb begin
    flags_d = load ? nxt : flags_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) flags_q <= '0;
    else            flags_q <= flags_d;
  end

  assign flags = flags_q;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !load |=> $stable(flags_q));

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    load |=> (flags_q == $past(nxt)));

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   op_sel,
  input  logic         flag_en,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_o
);

  localparam int SYNC_STAGES = 2;

  alu_op_e      op;
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic         rst_int_n;

  logic [W-1:0] as_b;
  logic         as_sub;
  logic [W-1:0] as_sum;
  logic         as_ovf;
  logic [W-1:0] mul_lo;
  logic         mul_ovf;
  logic [W-1:0] div_q;
  logic [W-1:0] div_rem;
  logic         div_zero;
  logic [W-1:0] log_res;
  alu_flags_t   flags_nxt;
  alu_flags_t   flags_cur;
  logic         flag_load;

  assign op = alu_op_e'(op_sel);

  // reset: asserted at once, released after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  // shared adder operand selection
  always_comb begin
    as_sub = (op == OP_SUB) || (op == OP_DEC);
    as_b   = ((op == OP_INC) || (op == OP_DEC)) ? {{(W-1){1'b0}}, 1'b1} : op_b;
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(as_b), .sub(as_sub), .sum(as_sum), .ovf(as_ovf)
  );

  alu8_mul #(.W(W)) u_mul (
    .a(op_a), .b(op_b), .prod_lo(mul_lo), .ovf(mul_ovf)
  );

  alu8_div #(.W(W)) u_div (
    .a(op_a), .b(op_b), .quot(div_q), .rem(div_rem), .by_zero(div_zero)
  );

  alu8_logic #(.W(W)) u_logic (
    .op(op), .a(op_a), .b(op_b), .res(log_res)
  );

  // result and flag next-state
  always_comb begin
    result      = '0;
    flags_nxt.o = 1'b0;
    result_we   = 1'b1;
    unique case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
        result      = as_sum;
        flags_nxt.o = as_ovf;
      end
      OP_MUL: begin
        result      = mul_lo;
        flags_nxt.o = mul_ovf;
      end
      OP_DIV: begin
        result      = div_q;
        flags_nxt.o = div_zero;
      end
      OP_CMP: begin
        result    = op_a;
        result_we = 1'b0;
      end
      OP_PASS: result = op_b;
      default: result = log_res;
    endcase
    if (op == OP_CMP) begin
      flags_nxt.z = (op_a == op_b);
      flags_nxt.s = (op_a < op_b);
    end else begin
      flags_nxt.z = (result == '0);
      flags_nxt.s = result[W-1];
    end
    flag_load = flag_en && (op != OP_PASS);
  end

  alu8_flag_reg u_flags (
    .clk(clk), .rst_int_n(rst_int_n), .load(flag_load),
    .nxt(flags_nxt), .flags(flags_cur)
  );

  assign flag_z = flags_cur.z;
  assign flag_s = flags_cur.s;
  assign flag_o = flags_cur.o;

  a_r3_div_identity: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op == OP_DIV && op_b != '0) |->
      (({{W{1'b0}}, div_q} * {{W{1'b0}}, op_b}) + {{W{1'b0}}, div_rem}
        == {{W{1'b0}}, op_a}));

  a_r3_div_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_en && op == OP_DIV && op_b == '0) |=> (flag_o && !flag_z));

  a_r2_mul_fit: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_en && op == OP_MUL && op_a == '0) |=> (!flag_o && flag_z));

  a_r5_rot_popcount: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op == OP_ROL || op == OP_ROR) |-> ($countones(result) == $countones(op_a)));

  a_r6_shl_fill: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op == OP_SHL) |-> (result[0] == 1'b0));

  a_r9_cmp_equal: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_en && op == OP_CMP && op_a == op_b) |=> (flag_z && !flag_s && !flag_o));

  a_r11_pass_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op == OP_PASS) |=> $stable({flag_z, flag_s, flag_o}));

  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_int_n |-> !(flag_z || flag_s || flag_o));

endmodule

// File: tb/tb_alu8_flags.sv
`timescale 1ns/1ps
module tb_alu8_flags;

  logic       clk;
  logic       rst_n;
  logic [7:0] op_a;
  logic [7:0] op_b;
  logic [3:0] op_sel;
  logic       flag_en;
  logic [7:0] result;
  logic       result_we;
  logic       flag_z, flag_s, flag_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit ez, es, eo;

  alu8_flags #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .flag_en(flag_en), .result(result), .result_we(result_we),
    .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic string tag(input int op);
    case (op)
      0, 1, 4, 5:  return "R1";
      2:           return "R2";
      3:           return "R3";
      6, 7, 8, 9:  return "R4";
      10, 11:      return "R5";
      12, 13:      return "R6";
      14:          return "R9";
      default:     return "R11";
    endcase
  endfunction

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  task automatic model(input int op, input int a, input int b,
                       output int r, output bit we,
                       output bit z, output bit s, output bit o);
    int t;
    we = 1; o = 0; r = 0;
    case (op)
      0:  begin t = sgn(a) + sgn(b); r = (a + b) % 256;       o = (t > 127) || (t < -128); end
      1:  begin t = sgn(a) - sgn(b); r = (a - b + 256) % 256; o = (t > 127) || (t < -128); end
      2:  begin t = a * b; r = t % 256; o = (t > 255); end
      3:  begin if (b == 0) begin r = 255; o = 1; end else r = a / b; end
      4:  begin t = sgn(a) + 1; r = (a + 1) % 256;   o = (t > 127); end
      5:  begin t = sgn(a) - 1; r = (a + 255) % 256; o = (t < -128); end
      6:  r = a & b;
      7:  r = a | b;
      8:  r = a ^ b;
      9:  r = 255 - a;
      10: r = ((a * 2) % 256) + (a / 128);
      11: r = (a / 2) + ((a % 2) * 128);
      12: r = (a * 2) % 256;
      13: r = a / 2;
      14: begin r = a; we = 0; end
      default: r = b;
    endcase
    if (op == 14) begin
      z = (a == b); s = (a < b);
    end else begin
      z = (r == 0); s = (r >= 128);
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input int op, input int a, input int b, input bit en);
    int r; bit we, z, s, o;
    @(negedge clk);
    op_sel = 4'(op); op_a = 8'(a); op_b = 8'(b); flag_en = en;
    #1;
    model(op, a, b, r, we, z, s, o);
    check(tag(op), $sformatf("result op=%0d a=%0h b=%0h", op, a, b), int'(result), r);
    check(tag(op), "result_we", int'(result_we), int'(we));
    @(posedge clk);
    #1;
    if (en && op != 15) begin ez = z; es = s; eo = o; end
    // R7 R8 R10: flag register contents after the edge
    check((op == 15) ? "R11" : (en ? "R7/R8" : "R10"),
          $sformatf("flags op=%0d a=%0h b=%0h en=%0d", op, a, b, en),
          int'({flag_z, flag_s, flag_o}), int'({ez, es, eo}));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op_a = 0; op_b = 0; op_sel = 0; flag_en = 0;
    ez = 0; es = 0; eo = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R10: flags cleared through reset and the two synchronizing edges
    #1 check("R10", "flags at reset", int'({flag_z, flag_s, flag_o}), 0);
    repeat (3) @(posedge clk);
    #1 check("R10", "flags after release", int'({flag_z, flag_s, flag_o}), 0);

    // corner cases
    run(0, 8'h7F, 8'h01, 1);   // R8 positive overflow
    run(1, 8'h80, 8'h01, 1);   // R8 negative overflow
    run(4, 8'h7F, 0, 1);       // R8 increment overflow
    run(5, 8'h80, 0, 1);       // R8 decrement overflow
    run(3, 8'h42, 0, 1);       // R3 divide by zero
    run(15, 8'h00, 8'h00, 1);  // R11 pass keeps flags
    run(14, 8'h10, 8'h20, 1);  // R9 less-than

    // full sweep: every code, every A, spread of B, enable toggling
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 256; bi += 15)
          run(op, a, bi, ((a + bi + op) % 5) != 0);
        run(op, a, a, 1);
        run(op, a, 1, (a % 3) != 0);
        run(op, a, 8'h80, 1);
      end
    end

    // R10: reset in mid-run clears flags at once
    run(3, 8'h05, 0, 1);
    @(negedge clk); rst_n = 0;
    #1 check("R10", "flags during reset", int'({flag_z, flag_s, flag_o}), 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    ez = 0; es = 0; eo = 0;
    run(14, 8'h33, 8'h33, 1);  // R9 equal after reset

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule